// File: doc/BRIEF.md
# Wake-up Identifier Matcher

This block sits behind a wake-up receiver's bit recovery stage. It accepts the demodulated wake-up bits one at a time, together with a pulse that marks the start of each frame. It checks the opening bits of every frame against a programmable identifier. There are four identifier modes:

- accept any frame;
- an 8-bit identifier held in the low byte register;
- a 16-bit identifier made of the high byte above the low byte;
- an 8-bit identifier that may equal either stored byte.

The result is a single-cycle acceptance pulse or a single-cycle rejection pulse.

The bit input is a valid/ready stream. The block never applies back-pressure. `bit_ready` stays high, and a bit counts as transferred on every cycle in which `bit_valid` is high. The upstream stage may therefore present a new bit on any cycle and need not wait.

The frame marker, the mode select, the two identifier bytes and the two result pulses are plain level or pulse pins. The mode and both bytes are captured when a frame starts and are held for that whole frame.

Top module: `wakeup_id_matcher`

## Requirements
- R1: After `rst_n` is low, or in the cycle after `soft_rst` is high, both result pulses are low and the captured mode is "any frame" (00). Bits that arrive before the next frame start then produce no pulse.
- R2: Mode 00 accepts every frame. A frame start raises `match_pulse` in the following cycle, and no bit of that frame raises either pulse.
- R3: Mode 01 compares 8 bits against `id_lo`. The first bit received is compared with bit 7.
- R4: Mode 10 compares 16 bits against {`id_hi`, `id_lo`}. The first bit received is compared with bit 7 of `id_hi`, and the ninth bit with bit 7 of `id_lo`.
- R5: Mode 11 compares 8 bits, taken first bit to bit 7, and accepts them when they equal `id_hi` or `id_lo`.
- R6: A failed comparison raises `miss_pulse` instead of `match_pulse`. Both pulses last one cycle, are never high together, and appear in the cycle after the bit that completes the identifier.
- R7: Each frame is compared exactly once. Bits after the completing bit are ignored until the next frame start, and a frame with too few bits gives no pulse.
- R8: The mode and the two identifier bytes are captured at frame start. Later changes to them do not affect the frame in progress.
- R9: A frame start discards any partially received bits. A bit presented in the same cycle as a frame start is dropped.
- R10: `bit_ready` is high whenever the block is out of reset, and a bit is taken on every cycle in which `bit_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous receiver reset; clears the frame state and returns the mode to 00 |
| frame_start | input | 1 | One-cycle marker at the start of a frame |
| bit_valid | input | 1 | A received bit is present on `bit_data` |
| bit_ready | output | 1 | The block accepts a bit this cycle (always high) |
| bit_data | input | 1 | Received bit value |
| mode_sel | input | 2 | Identifier mode: 00 any, 01 low 8 bits, 10 16 bits, 11 either byte |
| id_lo | input | 8 | Low identifier byte |
| id_hi | input | 8 | High identifier byte |
| match_pulse | output | 1 | One-cycle acceptance pulse |
| miss_pulse | output | 1 | One-cycle rejection pulse |

## Verification
The assertions assume that frame starts never come on two adjacent cycles. They also assume that a bit counts as transferred whenever `bit_valid` is high, because the block never stalls. The bench keeps to both assumptions: there are always idle or bit cycles between frame markers, and bits are driven one per cycle. The bench does send bits outside any frame, right after a soft reset, in the same cycle as a frame start, and after the completing bit. In each case it checks that these bits produce no pulse.

// File: rtl/wuid_pkg.sv
package wuid_pkg;
  typedef enum logic [1:0] {
    MODE_ANY     = 2'b00,
    MODE_LO8     = 2'b01,
    MODE_W16     = 2'b10,
    MODE_EITHER8 = 2'b11
  } id_mode_e;
endpackage

// File: rtl/wuid_cfg_latch.sv
module wuid_cfg_latch
  import wuid_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              capture,
  input  logic [1:0]        mode_in,
  input  logic [BYTE_W-1:0] lo_in,
  input  logic [BYTE_W-1:0] hi_in,
  output id_mode_e          mode_q,
  output logic [BYTE_W-1:0] lo_q,
  output logic [BYTE_W-1:0] hi_q
);
  // Configuration is frozen for the frame once the start marker is seen.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_ANY;
      lo_q   <= '0;
      hi_q   <= '0;
    end else if (soft_rst) begin
      mode_q <= MODE_ANY;
      lo_q   <= '0;
      hi_q   <= '0;
    end else if (capture) begin
      mode_q <= id_mode_e'(mode_in);
      lo_q   <= lo_in;
      hi_q   <= hi_in;
    end
  end
endmodule

// File: rtl/wuid_shifter.sv
module wuid_shifter #(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              frame_start,
  input  logic              arm_req,
  input  logic              fire,
  input  logic              bit_in,
  input  logic [CNT_W-1:0]  need,
  output logic [WORD_W-1:0] word_next,
  output logic              last_bit
);
  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;
  logic              armed;
  logic              take;

  assign take      = fire && armed && !frame_start;
  assign word_next = {shreg[WORD_W-2:0], bit_in};
  assign last_bit  = take && ((cnt + 1'b1) == need);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
      armed <= 1'b0;
    end else if (soft_rst) begin
      shreg <= '0;
      cnt   <= '0;
      armed <= 1'b0;
    end else if (frame_start) begin
      shreg <= '0;
      cnt   <= '0;
      armed <= arm_req;
    end else if (take) begin
      shreg <= word_next;
      cnt   <= cnt + 1'b1;
      if (last_bit) armed <= 1'b0;
    end
  end
endmodule

// File: rtl/wuid_compare.sv
module wuid_compare
  import wuid_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                soft_rst,
  input  id_mode_e            mode,
  input  logic                last_bit,
  input  logic                any_hit,
  input  logic [2*BYTE_W-1:0] word,
  input  logic [BYTE_W-1:0]   lo,
  input  logic [BYTE_W-1:0]   hi,
  output logic                match_pulse,
  output logic                miss_pulse
);
  logic hit;

  always_comb begin
    unique case (mode)
      MODE_LO8:     hit = (word[BYTE_W-1:0] == lo);
      MODE_W16:     hit = (word == {hi, lo});
      MODE_EITHER8: hit = (word[BYTE_W-1:0] == lo) || (word[BYTE_W-1:0] == hi);
      default:      hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_pulse <= 1'b0;
      miss_pulse  <= 1'b0;
    end else if (soft_rst) begin
      match_pulse <= 1'b0;
      miss_pulse  <= 1'b0;
    end else begin
      match_pulse <= any_hit || (last_bit && hit);
      miss_pulse  <= last_bit && !hit;
    end
  end
endmodule

// File: rtl/wakeup_id_matcher.sv
module wakeup_id_matcher
  import wuid_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              frame_start,
  input  logic              bit_valid,
  output logic              bit_ready,
  input  logic              bit_data,
  input  logic [1:0]        mode_sel,
  input  logic [BYTE_W-1:0] id_lo,
  input  logic [BYTE_W-1:0] id_hi,
  output logic              match_pulse,
  output logic              miss_pulse
);
  localparam int WORD_W = 2 * BYTE_W;
  localparam int CNT_W  = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] NEED_BYTE = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] NEED_WORD = CNT_W'(WORD_W);

  id_mode_e          mode_q;
  logic [BYTE_W-1:0] lo_q;
  logic [BYTE_W-1:0] hi_q;
  logic [CNT_W-1:0]  need;
  logic [WORD_W-1:0] word_next;
  logic              last_bit;
  logic              start_any;
  logic              fire;

  assign bit_ready = 1'b1;
  assign fire      = bit_valid && bit_ready;
  assign start_any = frame_start && (id_mode_e'(mode_sel) == MODE_ANY);

  always_comb begin
    unique case (mode_q)
      MODE_W16: need = NEED_WORD;
      default:  need = NEED_BYTE;
    endcase
  end

  wuid_cfg_latch #(.BYTE_W(BYTE_W)) cfg_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .capture  (frame_start),
    .mode_in  (mode_sel),
    .lo_in    (id_lo),
    .hi_in    (id_hi),
    .mode_q   (mode_q),
    .lo_q     (lo_q),
    .hi_q     (hi_q)
  );

  wuid_shifter #(.WORD_W(WORD_W), .CNT_W(CNT_W)) shf_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst    (soft_rst),
    .frame_start (frame_start),
    .arm_req     (!start_any),
    .fire        (fire),
    .bit_in      (bit_data),
    .need        (need),
    .word_next   (word_next),
    .last_bit    (last_bit)
  );

  wuid_compare #(.BYTE_W(BYTE_W)) cmp_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst    (soft_rst),
    .mode        (mode_q),
    .last_bit    (last_bit),
    .any_hit     (start_any),
    .word        (word_next),
    .lo          (lo_q),
    .hi          (hi_q),
    .match_pulse (match_pulse),
    .miss_pulse  (miss_pulse)
  );
endmodule

// File: rtl/wuid_matcher_chk.sv
module wuid_matcher_chk #(
  parameter int CNT_W = 5
) (
  input logic       clk,
  input logic       rst_n,
  input logic       soft_rst,
  input logic       frame_start,
  input logic       bit_valid,
  input logic       bit_ready,
  input logic [1:0] mode_sel,
  input logic       match_pulse,
  input logic       miss_pulse
);
  // Bits seen since the last frame start, saturating.
  logic [CNT_W-1:0] seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= '0;
    else if (soft_rst || frame_start) seen <= '0;
    else if (bit_valid && bit_ready && seen != '1) seen <= seen + 1'b1;
  end

  assert_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(match_pulse && miss_pulse));

  assert_anymode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && mode_sel == 2'b00 && !soft_rst) |=> match_pulse);

  assert_softrst_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!match_pulse && !miss_pulse));

  assert_onecycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (match_pulse && !(frame_start && mode_sel == 2'b00)) |=> !match_pulse);

  assert_miss_onecycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    miss_pulse |=> !miss_pulse);

  assert_lenpoint_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_pulse || (match_pulse && !$past(frame_start)))
      |-> (seen == CNT_W'(8) || seen == CNT_W'(16)));

  assert_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |-> bit_ready);
endmodule

bind wakeup_id_matcher wuid_matcher_chk #(.CNT_W(5)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .soft_rst    (soft_rst),
  .frame_start (frame_start),
  .bit_valid   (bit_valid),
  .bit_ready   (bit_ready),
  .mode_sel    (mode_sel),
  .match_pulse (match_pulse),
  .miss_pulse  (miss_pulse)
);

// File: tb/wakeup_id_matcher_tb_top.sv
module wakeup_id_matcher_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0]  mode;
    logic [7:0]  hi;
    logic [7:0]  lo;
    logic [4:0]  nbits;
    logic [15:0] bits;
    logic        em;
    logic        ex;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'b01, 8'h00, 8'hA5, 5'd8,  16'hA500, 1'b1, 1'b0},  // R3 match
    '{2'b01, 8'h00, 8'hA5, 5'd8,  16'hA400, 1'b0, 1'b1},  // R3 miss
    '{2'b10, 8'h3C, 8'hC3, 5'd16, 16'h3CC3, 1'b1, 1'b0},  // R4 match
    '{2'b10, 8'h3C, 8'hC3, 5'd16, 16'hC33C, 1'b0, 1'b1},  // R4 byte order
    '{2'b11, 8'h12, 8'h34, 5'd8,  16'h1200, 1'b1, 1'b0},  // R5 high byte
    '{2'b11, 8'h12, 8'h34, 5'd8,  16'h3400, 1'b1, 1'b0},  // R5 low byte
    '{2'b11, 8'h12, 8'h34, 5'd8,  16'h5600, 1'b0, 1'b1},  // R5 neither
    '{2'b00, 8'h77, 8'h88, 5'd0,  16'h0000, 1'b1, 1'b0},  // R2 empty frame
    '{2'b00, 8'h77, 8'h88, 5'd8,  16'hFF00, 1'b1, 1'b0},  // R2 bits ignored
    '{2'b01, 8'h00, 8'h0F, 5'd12, 16'h0FF0, 1'b1, 1'b0},  // R7 extra bits
    '{2'b01, 8'h00, 8'h0F, 5'd5,  16'h0800, 1'b0, 1'b0},  // R7 short frame
    '{2'b10, 8'h3C, 8'hC3, 5'd8,  16'h3C00, 1'b0, 1'b0}   // R7 half word
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       soft_rst = 1'b0;
  logic       frame_start = 1'b0;
  logic       bit_valid = 1'b0;
  logic       bit_data = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic [7:0] id_lo = 8'h00;
  logic [7:0] id_hi = 8'h00;
  logic       bit_ready;
  logic       match_pulse;
  logic       miss_pulse;

  int total = 0;
  int bad = 0;
  int macc = 0;
  int xacc = 0;
  logic last_m, last_x;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wakeup_id_matcher dut_i (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .frame_start(frame_start),
    .bit_valid(bit_valid), .bit_ready(bit_ready), .bit_data(bit_data),
    .mode_sel(mode_sel), .id_lo(id_lo), .id_hi(id_hi),
    .match_pulse(match_pulse), .miss_pulse(miss_pulse)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive one cycle of inputs, then sample the outputs of that edge.
  task automatic step(input logic fs, input logic bv, input logic bd);
    frame_start = fs;
    bit_valid   = bv;
    bit_data    = bd;
    @(negedge clk);
    last_m = match_pulse;
    last_x = miss_pulse;
    macc += int'(last_m);
    xacc += int'(last_x);
  endtask

  task automatic send_bits(input logic [15:0] bits, input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b1, bits[15-i]);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 match after reset", int'(match_pulse), 0);
    check("R1 miss after reset", int'(miss_pulse), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 ready", int'(bit_ready), 1);

    // Table of frames.
    for (int v = 0; v < NV; v++) begin
      mode_sel = VECS[v].mode;
      id_hi = VECS[v].hi;
      id_lo = VECS[v].lo;
      macc = 0;
      xacc = 0;
      step(1'b1, 1'b0, 1'b0);
      send_bits(VECS[v].bits, int'(VECS[v].nbits));
      idle(2);
      check($sformatf("R3/R4/R5/R2/R7 vec%0d match count", v), macc, int'(VECS[v].em));
      check($sformatf("R6 vec%0d miss count", v), xacc, int'(VECS[v].ex));
    end

    // R1: bits before any frame start after reset give nothing.
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    mode_sel = 2'b01;
    id_lo = 8'h00;
    macc = 0;
    xacc = 0;
    send_bits(16'h0000, 16);
    idle(1);
    check("R1 no frame after reset", macc + xacc, 0);

    // R1: soft reset mid-frame; remaining bits produce nothing.
    id_lo = 8'hF0;
    macc = 0;
    xacc = 0;
    step(1'b1, 1'b0, 1'b0);
    send_bits(16'hF000, 4);
    soft_rst = 1'b1;
    step(1'b0, 1'b0, 1'b0);
    soft_rst = 1'b0;
    send_bits(16'h0000, 8);
    idle(1);
    check("R1 soft reset quiets frame", macc + xacc, 0);

    // R2: pulse timing for mode 00.
    mode_sel = 2'b00;
    step(1'b1, 1'b0, 1'b0);
    check("R2 match in cycle after start", int'(last_m), 1);
    step(1'b0, 1'b0, 1'b0);
    check("R2 match lasts one cycle", int'(last_m), 0);

    // R6: miss appears on the completing bit only, for one cycle.
    mode_sel = 2'b01;
    id_lo = 8'h81;
    macc = 0;
    xacc = 0;
    step(1'b1, 1'b0, 1'b0);
    send_bits(16'h8000, 7);
    check("R6 no pulse before eighth bit", macc + xacc, 0);
    step(1'b0, 1'b1, 1'b0);
    check("R6 miss on completing bit", int'(last_x), 1);
    check("R6 no match with miss", int'(last_m), 0);
    step(1'b0, 1'b0, 1'b0);
    check("R6 miss lasts one cycle", int'(last_x), 0);

    // R8: configuration changed mid-frame is not used.
    mode_sel = 2'b01;
    id_lo = 8'hAA;
    macc = 0;
    xacc = 0;
    step(1'b1, 1'b0, 1'b0);
    mode_sel = 2'b10;
    id_lo = 8'h55;
    id_hi = 8'h55;
    send_bits(16'hAA00, 8);
    idle(1);
    check("R8 captured config match", macc, 1);
    check("R8 captured config miss", xacc, 0);

    // R9: restart discards partial bits.
    mode_sel = 2'b01;
    id_lo = 8'h3A;
    macc = 0;
    xacc = 0;
    step(1'b1, 1'b0, 1'b0);
    send_bits(16'hFF00, 3);
    step(1'b1, 1'b0, 1'b0);
    send_bits(16'h3A00, 8);
    idle(1);
    check("R9 restart match", macc, 1);
    check("R9 restart miss", xacc, 0);

    // R9: bit alongside frame start is dropped.
    macc = 0;
    xacc = 0;
    step(1'b1, 1'b1, 1'b1);
    send_bits(16'h3A00, 8);
    idle(1);
    check("R9 same-cycle bit dropped match", macc, 1);
    check("R9 same-cycle bit dropped miss", xacc, 0);

    finish_run();
  end
endmodule